// File: doc/BRIEF.md
# Multi-Processor Masked Interrupt Router

This block gathers up to 64 device interrupt requests into one shared raw request register and routes them to four processors. Each processor owns a mask register and a masked status register, and has one level-sensitive interrupt output. Devices raise requests by pulsing a set strobe with a bit vector, and withdraw them by pulsing a clear strobe with a bit vector. Software loads a processor's mask through a small write port and inspects the mask, status and raw registers through a read port that is selected by index.

The status registers are not a live AND of mask and raw. They change only on discrete events: a mask write, a set strobe or a clear strobe. Each processor's output works as a sticky "currently interrupting" flag. An event with an unmasked hit sets the flag. It falls only when a clear strobe leaves that processor's status empty. Every processor output is meant for the same interrupt level at the processor, the second-lowest device level.

Every input is accepted on the clock edge where it is sampled. The block has no back-pressure, so the ports carry no valid/ready pair. A strobe or write that is high for one cycle is one event.

Top module: `irq_router`

## Requirements
- R1: After reset, all masks, all status registers and the raw register read as zero, and every interrupt output is low.
- R2: A mask write whose data ANDed with the raw register is nonzero loads that processor's status with the AND. It also sets its interrupt output, which is visible after the clock edge that samples the write.
- R3: A mask write whose data ANDed with the raw register is zero stores only the mask. The processor's status and interrupt output keep their previous values.
- R4: A set strobe ORs its vector into the raw register. For every processor whose current mask shares a bit with the vector, it ORs the whole vector, including unmasked bits, into that processor's status and sets the interrupt output.
- R5: A set strobe whose vector shares no bit with a processor's mask leaves that processor's status and interrupt output unchanged.
- R6: A clear strobe removes its bits from the raw register and from every status register. A processor whose status becomes zero drops its interrupt output. A processor whose status stays nonzero keeps the output high.
- R7: When set and clear strobes arrive in the same cycle, the set is applied first and the clear second, so a bit present in both ends up cleared everywhere.
- R8: When a mask write coincides with a strobe, the strobe is applied first. The mask write is then evaluated against the updated raw register.
- R9: The read port returns its value one cycle after the selection is presented. The index rd_reg selects the register: 0 gives the mask of processor rd_cpu, 1 gives its status, 2 gives the raw register, and 3 to 7 give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_en | input | 1 | Request-set strobe |
| set_vec | input | 64 | Bits to raise |
| clr_en | input | 1 | Request-clear strobe |
| clr_vec | input | 64 | Bits to drop |
| wr_en | input | 1 | Mask write enable |
| wr_cpu | input | 2 | Processor whose mask is written |
| wr_data | input | 64 | New mask value |
| rd_cpu | input | 2 | Processor selected for reading |
| rd_reg | input | 3 | Register kind selected for reading |
| rd_data | output | 64 | Registered read data |
| irq_o | output | 4 | Per-processor interrupt outputs |

## Verification
Directed sequences separate the two kinds of mask write: a write that hits the raw requests loads the status, and a write that misses keeps a stale status. Set vectors that carry bits outside a processor's mask show whether the whole vector is ORed in or only its masked part. Partial and full clears, and clears aimed at processors that are not interrupting, show when an output drops. Coinciding set/clear strobes and coinciding strobe/write pairs fix the order of operations. A long sweep of sparse vectors over eight spread bit positions then exercises all event combinations against an arithmetic model of the requirements.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [2:0] {
    RD_MASK = 3'd0,
    RD_STAT = 3'd1,
    RD_RAW  = 3'd2
  } rd_kind_e;
endpackage

// File: rtl/irq_raw_reg.sv
module irq_raw_reg #(
  parameter int REQ_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REQ_W-1:0] set_vec,
  input  logic             clr_en,
  input  logic [REQ_W-1:0] clr_vec,
  output logic [REQ_W-1:0] raw_q,
  output logic [REQ_W-1:0] raw_next
);
  logic [REQ_W-1:0] after_set;

  // set is applied before clear
  always_comb begin
    after_set = set_en ? (raw_q | set_vec) : raw_q;
    raw_next  = clr_en ? (after_set & ~clr_vec) : after_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_next;
  end
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int REQ_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REQ_W-1:0] set_vec,
  input  logic             clr_en,
  input  logic [REQ_W-1:0] clr_vec,
  input  logic [REQ_W-1:0] raw_next,
  input  logic             wr_sel,
  input  logic [REQ_W-1:0] wr_data,
  output logic [REQ_W-1:0] mask_q,
  output logic [REQ_W-1:0] stat_q,
  output logic             irq_q
);
  logic             set_hit;
  logic [REQ_W-1:0] stat_s;
  logic             flag_s;
  logic [REQ_W-1:0] stat_c;
  logic             flag_c;
  logic [REQ_W-1:0] wr_and;
  logic             wr_hit;
  logic [REQ_W-1:0] stat_d;
  logic             irq_d;
  logic [REQ_W-1:0] mask_d;

  always_comb begin
    // stage 1: set strobe, tested against the mask held before this cycle
    set_hit = set_en && (|(mask_q & set_vec));
    stat_s  = set_hit ? (stat_q | set_vec) : stat_q;
    flag_s  = irq_q | set_hit;
    // stage 2: clear strobe
    stat_c  = clr_en ? (stat_s & ~clr_vec) : stat_s;
    flag_c  = (clr_en && (stat_c == '0)) ? 1'b0 : flag_s;
    // stage 3: mask write against the raw value after both strobes
    wr_and  = wr_data & raw_next;
    wr_hit  = wr_sel && (|wr_and);
    stat_d  = wr_hit ? wr_and : stat_c;
    irq_d   = wr_hit ? 1'b1 : flag_c;
    mask_d  = wr_sel ? wr_data : mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int REQ_W   = 64,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CPU_W-1:0]              rd_cpu,
  input  logic [2:0]                    rd_reg,
  input  logic [NUM_CPU-1:0][REQ_W-1:0] mask_all,
  input  logic [NUM_CPU-1:0][REQ_W-1:0] stat_all,
  input  logic [REQ_W-1:0]              raw_q,
  output logic [REQ_W-1:0]              rd_data
);
  logic [REQ_W-1:0] sel_d;

  always_comb begin
    case (rd_kind_e'(rd_reg))
      RD_MASK: sel_d = mask_all[rd_cpu];
      RD_STAT: sel_d = stat_all[rd_cpu];
      RD_RAW:  sel_d = raw_q;
      default: sel_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= sel_d;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_CPU = 4,
  parameter int REQ_W   = 64,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [REQ_W-1:0]   set_vec,
  input  logic               clr_en,
  input  logic [REQ_W-1:0]   clr_vec,
  input  logic               wr_en,
  input  logic [CPU_W-1:0]   wr_cpu,
  input  logic [REQ_W-1:0]   wr_data,
  input  logic [CPU_W-1:0]   rd_cpu,
  input  logic [2:0]         rd_reg,
  output logic [REQ_W-1:0]   rd_data,
  output logic [NUM_CPU-1:0] irq_o
);
  logic [REQ_W-1:0]              raw_q;
  logic [REQ_W-1:0]              raw_next;
  logic [NUM_CPU-1:0][REQ_W-1:0] mask_all;
  logic [NUM_CPU-1:0][REQ_W-1:0] stat_all;

  irq_raw_reg #(.REQ_W(REQ_W)) raw_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_en),
    .set_vec  (set_vec),
    .clr_en   (clr_en),
    .clr_vec  (clr_vec),
    .raw_q    (raw_q),
    .raw_next (raw_next)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic wr_sel;
    assign wr_sel = wr_en && (wr_cpu == CPU_W'(c));

    irq_cpu_slice #(.REQ_W(REQ_W)) slice_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en),
      .set_vec  (set_vec),
      .clr_en   (clr_en),
      .clr_vec  (clr_vec),
      .raw_next (raw_next),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .mask_q   (mask_all[c]),
      .stat_q   (stat_all[c]),
      .irq_q    (irq_o[c])
    );
  end

  irq_read_mux #(.NUM_CPU(NUM_CPU), .REQ_W(REQ_W)) rd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cpu   (rd_cpu),
    .rd_reg   (rd_reg),
    .mask_all (mask_all),
    .stat_all (stat_all),
    .raw_q    (raw_q),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CPU = 4,
  parameter int REQ_W   = 64,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          set_en,
  input logic [REQ_W-1:0]              set_vec,
  input logic                          clr_en,
  input logic [REQ_W-1:0]              clr_vec,
  input logic                          wr_en,
  input logic [CPU_W-1:0]              wr_cpu,
  input logic [REQ_W-1:0]              wr_data,
  input logic [NUM_CPU-1:0]            irq_o,
  input logic [NUM_CPU-1:0][REQ_W-1:0] mask_all,
  input logic [NUM_CPU-1:0][REQ_W-1:0] stat_all,
  input logic [REQ_W-1:0]              raw_q
);
  // R6: a full clear empties raw and drops every output
  p_full_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && (clr_vec == '1) && !wr_en) |=> ((raw_q == '0) && (irq_o == '0)));

  // R4: set bits are present in raw afterwards unless also cleared
  p_set_into_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    // R6: output high exactly while the status register holds bits
    p_flag_tracks_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] == (stat_all[c] != '0));

    // R4: overlapping set raises the output and lands the full vector
    p_set_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr_en && !wr_en && ((mask_all[c] & set_vec) != '0))
      |=> (irq_o[c] && ((stat_all[c] & $past(set_vec)) == $past(set_vec))));

    // R2: hitting mask write loads the AND
    p_mask_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en && wr_en && (wr_cpu == CPU_W'(c)) && ((wr_data & raw_q) != '0))
      |=> (irq_o[c] && (stat_all[c] == $past(wr_data & raw_q))));

    // R3: missing mask write leaves status and output alone
    p_mask_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en && wr_en && (wr_cpu == CPU_W'(c)) && ((wr_data & raw_q) == '0))
      |=> ($stable(stat_all[c]) && $stable(irq_o[c])));
  end
endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU), .REQ_W(REQ_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .set_en   (set_en),
  .set_vec  (set_vec),
  .clr_en   (clr_en),
  .clr_vec  (clr_vec),
  .wr_en    (wr_en),
  .wr_cpu   (wr_cpu),
  .wr_data  (wr_data),
  .irq_o    (irq_o),
  .mask_all (mask_all),
  .stat_all (stat_all),
  .raw_q    (raw_q)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
  localparam int NC = 4;
  localparam int W  = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          set_en, clr_en, wr_en;
  logic [W-1:0]  set_vec, clr_vec, wr_data;
  logic [1:0]    wr_cpu, rd_cpu;
  logic [2:0]    rd_reg;
  logic [W-1:0]  rd_data;
  logic [NC-1:0] irq_o;

  irq_router #(.NUM_CPU(NC), .REQ_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_vec(set_vec),
    .clr_en(clr_en), .clr_vec(clr_vec), .wr_en(wr_en), .wr_cpu(wr_cpu),
    .wr_data(wr_data), .rd_cpu(rd_cpu), .rd_reg(rd_reg),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0]  m_mask [NC];
  logic [W-1:0]  m_stat [NC];
  logic [W-1:0]  m_raw;
  logic [NC-1:0] m_irq;

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected state from the requirements: set, then clear, then mask write
  task automatic model(input logic se, input logic [W-1:0] sv,
                       input logic ce, input logic [W-1:0] cv,
                       input logic we, input int wc, input logic [W-1:0] wd);
    logic [W-1:0] rn;
    rn = m_raw;
    if (se) rn = rn | sv;
    if (ce) rn = rn & ~cv;
    for (int c = 0; c < NC; c++) begin
      if (se && ((m_mask[c] & sv) != '0)) begin
        m_stat[c] = m_stat[c] | sv;
        m_irq[c] = 1'b1;
      end
      if (ce) begin
        m_stat[c] = m_stat[c] & ~cv;
        if (m_stat[c] == '0) m_irq[c] = 1'b0;
      end
      if (we && wc == c) begin
        if ((wd & rn) != '0) begin
          m_stat[c] = wd & rn;
          m_irq[c] = 1'b1;
        end
        m_mask[c] = wd;
      end
    end
    m_raw = rn;
  endtask

  // one event cycle; outputs checked right after the sampling edge
  task automatic step(input string req, input logic se, input logic [W-1:0] sv,
                      input logic ce, input logic [W-1:0] cv,
                      input logic we, input int wc, input logic [W-1:0] wd);
    @(negedge clk);
    set_en = se; set_vec = sv; clr_en = ce; clr_vec = cv;
    wr_en = we; wr_cpu = 2'(wc); wr_data = wd;
    model(se, sv, ce, cv, we, wc, wd);
    @(negedge clk);
    set_en = 0; clr_en = 0; wr_en = 0;
    chk(req, "irq_o", W'(irq_o), W'(m_irq));
  endtask

  task automatic rd(input int cpu, input int kind, output logic [W-1:0] val);
    @(negedge clk);
    rd_cpu = 2'(cpu); rd_reg = 3'(kind);
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic check_all(input string req);
    logic [W-1:0] v;
    for (int c = 0; c < NC; c++) begin
      rd(c, 0, v); chk(req, $sformatf("mask%0d", c), v, m_mask[c]);
      rd(c, 1, v); chk(req, $sformatf("status%0d", c), v, m_stat[c]);
    end
    rd(0, 2, v); chk(req, "raw", v, m_raw);
    chk(req, "irq_o", W'(irq_o), W'(m_irq));
  endtask

  function automatic logic [W-1:0] bit_at(input int n);
    return W'(1) << n;
  endfunction

  function automatic logic [W-1:0] sparse(input logic [7:0] b);
    int pos [8] = '{0, 1, 5, 17, 31, 32, 48, 63};
    logic [W-1:0] v = '0;
    for (int k = 0; k < 8; k++) if (b[k]) v = v | bit_at(pos[k]);
    return v;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    rst_n = 0; set_en = 0; clr_en = 0; wr_en = 0;
    set_vec = '0; clr_vec = '0; wr_data = '0; wr_cpu = 0; rd_cpu = 0; rd_reg = 0;
    for (int c = 0; c < NC; c++) begin m_mask[c] = '0; m_stat[c] = '0; end
    m_raw = '0; m_irq = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    check_all("R1");

    // raw bits with no mask anywhere: nobody interrupts
    step("R5", 1, bit_at(3) | bit_at(40), 0, '0, 0, 0, '0);
    check_all("R5");

    // mask write hitting bit 40 loads status with the AND only
    step("R2", 0, '0, 0, '0, 1, 1, bit_at(40) | bit_at(7));
    check_all("R2");

    // mask writes with no hit keep stale status
    step("R3", 0, '0, 0, '0, 1, 1, bit_at(7));
    step("R3", 0, '0, 0, '0, 1, 2, bit_at(9));
    check_all("R3");

    // full vector lands in status of each overlapping processor
    step("R4", 1, bit_at(7) | bit_at(9) | bit_at(50), 0, '0, 0, 0, '0);
    check_all("R4");

    // partial clear keeps outputs, full clear drops them
    step("R6", 0, '0, 1, bit_at(50), 0, 0, '0);
    check_all("R6");
    step("R6", 0, '0, 1, bit_at(40) | bit_at(7) | bit_at(9), 0, 0, '0);
    check_all("R6");

    // set and clear of the same bit in one cycle: cleared
    step("R7", 1, bit_at(9), 1, bit_at(9), 0, 0, '0);
    check_all("R7");

    // strobe and mask write together: write sees updated raw
    step("R8", 1, bit_at(20), 0, '0, 1, 3, bit_at(20));
    check_all("R8");
    step("R8", 0, '0, 1, bit_at(3), 1, 0, bit_at(3));
    check_all("R8");

    // unused read indices return zero
    for (int k = 3; k < 8; k++) begin
      rd(1, k, v); chk("R9", $sformatf("index%0d", k), v, '0);
    end

    // sweep of sparse events against the model
    for (int i = 0; i < 600; i++) begin
      logic se, ce, we;
      int wc;
      logic [W-1:0] sv, cv, wd;
      se = ($urandom % 3) == 0;
      ce = ($urandom % 4) == 0;
      we = ($urandom % 3) == 0;
      wc = $urandom % NC;
      sv = sparse(8'($urandom & $urandom));
      cv = sparse(8'($urandom & $urandom));
      wd = sparse(8'($urandom));
      step("R4 sweep", se, sv, ce, cv, we, wc, wd);
      if (i % 10 == 9) check_all("R6 sweep");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule